// File: doc/BRIEF.md
# Vectored Interrupt Priority Core

This block keeps the pending, in-service and trigger-mode state for a set of numbered interrupt vectors (256 by default) and decides when to ask the processor for service. Sources post a vector number together with its trigger mode. The processor acknowledges to take the winning vector and later signals end-of-interrupt to retire it. A lower vector number always means a higher priority. A new request is raised only when the best pending vector beats the best vector already in service.

The block also produces a processor priority byte. It is built from the priority class (upper nibble) of the task priority input and of the in-service winner. Every state array can be read back one 32-bit word at a time through a word select. A global enable gates acknowledge: while it is low, acknowledge hands out nothing and leaves all state as it was.

Top module: `vip_core`

## Requirements
- R1: Vector v is held in readback word v>>5 at bit v&31 of each array. `rd_sel_i` picks the word, and the three readback outputs show that word of the state one clock after the select is applied.
- R2: The priority search treats the lowest set index across all words as the winner, including across word boundaries (for example 31 beats 32 and 255).
- R3: A post sets the vector's pending bit. It sets the vector's trigger-mode bit when `post_level_i` is 1 (level) and clears it when `post_level_i` is 0 (edge).
- R4: `irq_o` is 1 exactly when some vector is pending and either nothing is in service or the pending winner index is strictly lower than the in-service winner index. Equal indices give 0.
- R5: An acknowledge with the block enabled and something pending clears the winner's pending bit and sets its in-service bit. On the next clock it shows `ack_valid_o`=1 with that vector on `ack_vec_o`.
- R6: An acknowledge while disabled, or with nothing pending, changes no state and gives `ack_valid_o`=0 on the next clock.
- R7: End-of-interrupt clears the lowest set in-service bit. With the in-service array empty it changes nothing.
- R8: `ppr_o` equals `tpr_i` when tpr_i[7:4] >= (in-service winner >> 4), with an empty in-service array counting as class 0. Otherwise `ppr_o` equals the in-service class shifted left by 4.
- R9: When a post and an acknowledge of the same vector fall in the same clock, the acknowledge is applied first. The vector ends both in service and still pending.
- R10: Synchronous active-high reset clears all three arrays and the acknowledge outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Global enable for acknowledge |
| post_valid_i | input | 1 | Post strobe |
| post_vec_i | input | 8 | Vector being posted |
| post_level_i | input | 1 | Trigger mode of the post: 1 level, 0 edge |
| ack_req_i | input | 1 | Acknowledge strobe |
| ack_valid_o | output | 1 | A vector was handed out by the last acknowledge |
| ack_vec_o | output | 8 | Vector handed out |
| eoi_i | input | 1 | End-of-interrupt strobe |
| tpr_i | input | 8 | Task priority |
| irq_o | output | 1 | Interrupt request to the processor |
| ppr_o | output | 8 | Processor priority |
| rd_sel_i | input | 3 | Readback word select |
| rd_irr_o | output | 32 | Pending array word |
| rd_isr_o | output | 32 | In-service array word |
| rd_tmr_o | output | 32 | Trigger-mode array word |

## Verification
Vectors are posted in scattered words, in ascending order and in descending order. This shows whether the search honours the lowest index across word boundaries or only within one word. Interleaved acknowledge and end-of-interrupt sequences separate the strict-less-than request rule from a less-or-equal rule, and a task priority above and below the in-service class selects each branch of the priority formula. A disabled acknowledge, an empty acknowledge, an end-of-interrupt on an empty array and a same-cycle post and acknowledge of one vector each show, through readback, whether the state was left alone or updated in the required order.

// File: rtl/vip_pkg.sv
package vip_pkg;
  // Trigger mode carried with a post
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } vip_trig_e;

  // Width of one priority class field (upper part of a vector index)
  localparam int unsigned CLASS_SHIFT = 4;
endpackage

// File: rtl/vip_word_enc.sv
// Finds the lowest set bit inside one word.
module vip_word_enc #(
  parameter int unsigned W = 32,
  localparam int unsigned POS_W = $clog2(W)
) (
  input  logic [W-1:0]     bits_i,
  output logic             hit_o,
  output logic [POS_W-1:0] pos_o
);
  always_comb begin
    hit_o = 1'b0;
    pos_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (bits_i[i]) begin
        hit_o = 1'b1;
        pos_o = POS_W'(i);
      end
    end
  end
endmodule

// File: rtl/vip_prio_enc.sv
// Lowest-index search over the whole vector space, one word encoder per word.
module vip_prio_enc #(
  parameter int unsigned N_VEC  = 256,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NW    = N_VEC / WORD_W,
  localparam int unsigned IDX_W = $clog2(N_VEC),
  localparam int unsigned POS_W = $clog2(WORD_W)
) (
  input  logic [N_VEC-1:0] vec_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [NW-1:0]    word_hit;
  logic [POS_W-1:0] word_pos [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    vip_word_enc #(.W(WORD_W)) u_enc (
      .bits_i(vec_i[w*WORD_W +: WORD_W]),
      .hit_o (word_hit[w]),
      .pos_o (word_pos[w])
    );
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int w = NW - 1; w >= 0; w--) begin
      if (word_hit[w]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(w * WORD_W) | IDX_W'(word_pos[w]);
      end
    end
  end
endmodule

// File: rtl/vip_class_prio.sv
// Processor priority from the task class and the in-service class.
module vip_class_prio #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] tpr_i,
  input  logic              isr_hit_i,
  input  logic [PRIO_W-1:0] isr_idx_i,
  output logic [PRIO_W-1:0] ppr_o
);
  import vip_pkg::*;
  logic [PRIO_W-1:0] task_cls;
  logic [PRIO_W-1:0] svc_cls;

  always_comb begin
    task_cls = tpr_i >> CLASS_SHIFT;
    svc_cls  = isr_hit_i ? (isr_idx_i >> CLASS_SHIFT) : '0;
    if (task_cls >= svc_cls) ppr_o = tpr_i;
    else                     ppr_o = svc_cls << CLASS_SHIFT;
  end
endmodule

// File: rtl/vip_core.sv
module vip_core #(
  parameter int unsigned N_VEC  = 256,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NW     = N_VEC / WORD_W,
  localparam int unsigned IDX_W  = $clog2(N_VEC),
  localparam int unsigned WSEL_W = $clog2(NW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic              post_valid_i,
  input  logic [IDX_W-1:0]  post_vec_i,
  input  logic              post_level_i,
  input  logic              ack_req_i,
  output logic              ack_valid_o,
  output logic [IDX_W-1:0]  ack_vec_o,
  input  logic              eoi_i,
  input  logic [IDX_W-1:0]  tpr_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  ppr_o,
  input  logic [WSEL_W-1:0] rd_sel_i,
  output logic [WORD_W-1:0] rd_irr_o,
  output logic [WORD_W-1:0] rd_isr_o,
  output logic [WORD_W-1:0] rd_tmr_o
);
  logic [N_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [N_VEC-1:0] irr_n, isr_n, tmr_n;
  logic             irr_hit, isr_hit;
  logic [IDX_W-1:0] irr_idx, isr_idx;
  logic             ack_take;

  vip_prio_enc #(.N_VEC(N_VEC), .WORD_W(WORD_W)) u_irr_enc (
    .vec_i(irr_q), .hit_o(irr_hit), .idx_o(irr_idx)
  );
  vip_prio_enc #(.N_VEC(N_VEC), .WORD_W(WORD_W)) u_isr_enc (
    .vec_i(isr_q), .hit_o(isr_hit), .idx_o(isr_idx)
  );
  vip_class_prio #(.PRIO_W(IDX_W)) u_ppr (
    .tpr_i(tpr_i), .isr_hit_i(isr_hit), .isr_idx_i(isr_idx), .ppr_o(ppr_o)
  );

  assign ack_take = ack_req_i && enable_i && irr_hit;
  assign irq_o    = irr_hit && (!isr_hit || (irr_idx < isr_idx));

  // Acknowledge first, then post; end-of-interrupt before acknowledge
  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (ack_take) irr_n[irr_idx] = 1'b0;
    if (post_valid_i) begin
      irr_n[post_vec_i] = 1'b1;
      tmr_n[post_vec_i] = post_level_i;
    end
    if (eoi_i && isr_hit) isr_n[isr_idx] = 1'b0;
    if (ack_take) isr_n[irr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q       <= '0;
      isr_q       <= '0;
      tmr_q       <= '0;
      ack_valid_o <= 1'b0;
      ack_vec_o   <= '0;
      rd_irr_o    <= '0;
      rd_isr_o    <= '0;
      rd_tmr_o    <= '0;
    end else begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      tmr_q <= tmr_n;
      if (ack_req_i) begin
        ack_valid_o <= ack_take;
        ack_vec_o   <= ack_take ? irr_idx : '0;
      end else begin
        ack_valid_o <= 1'b0;
      end
      rd_irr_o <= irr_q[rd_sel_i*WORD_W +: WORD_W];
      rd_isr_o <= isr_q[rd_sel_i*WORD_W +: WORD_W];
      rd_tmr_o <= tmr_q[rd_sel_i*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/vip_core_chk.sv
module vip_core_chk #(
  parameter int unsigned N_VEC = 256,
  localparam int unsigned IDX_W = $clog2(N_VEC)
) (
  input logic             clk,
  input logic             rst,
  input logic             enable_i,
  input logic             post_valid_i,
  input logic [IDX_W-1:0] post_vec_i,
  input logic             post_level_i,
  input logic             ack_req_i,
  input logic             eoi_i,
  input logic             ack_valid_o,
  input logic [IDX_W-1:0] ack_vec_o,
  input logic             irq_o,
  input logic [IDX_W-1:0] ppr_o,
  input logic [IDX_W-1:0] tpr_i,
  input logic [N_VEC-1:0] irr_q,
  input logic [N_VEC-1:0] isr_q,
  input logic [N_VEC-1:0] tmr_q,
  input logic             irr_hit,
  input logic [IDX_W-1:0] irr_idx,
  input logic             isr_hit
);
  assert_post_sets_R3: assert property (@(posedge clk) disable iff (rst)
    post_valid_i |=> (irr_q[$past(post_vec_i)] && tmr_q[$past(post_vec_i)] == $past(post_level_i)));

  assert_irq_needs_pending_R4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (irr_q != '0));

  assert_ack_moves_R5: assert property (@(posedge clk) disable iff (rst)
    (ack_req_i && enable_i && irr_hit) |=>
      (ack_valid_o && ack_vec_o == $past(irr_idx) && isr_q[$past(irr_idx)]));

  assert_ack_none_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_req_i && !(enable_i && irr_hit)) |=> !ack_valid_o);

  assert_eoi_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && !isr_hit && !ack_req_i) |=> (isr_q == '0));

  assert_ppr_floor_R8: assert property (@(posedge clk) disable iff (rst)
    ppr_o >= tpr_i);

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (irr_q == '0 && isr_q == '0 && tmr_q == '0 && !ack_valid_o));
endmodule

bind vip_core vip_core_chk #(.N_VEC(N_VEC)) u_chk (
  .clk(clk), .rst(rst), .enable_i(enable_i), .post_valid_i(post_valid_i),
  .post_vec_i(post_vec_i), .post_level_i(post_level_i), .ack_req_i(ack_req_i),
  .eoi_i(eoi_i), .ack_valid_o(ack_valid_o), .ack_vec_o(ack_vec_o),
  .irq_o(irq_o), .ppr_o(ppr_o), .tpr_i(tpr_i), .irr_q(irr_q), .isr_q(isr_q),
  .tmr_q(tmr_q), .irr_hit(irr_hit), .irr_idx(irr_idx), .isr_hit(isr_hit)
);

// File: tb/tb_vip_core.sv
module tb_vip_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable_i = 1'b1;
  logic post_valid_i = 1'b0;
  logic [7:0] post_vec_i = '0;
  logic post_level_i = 1'b0;
  logic ack_req_i = 1'b0;
  logic eoi_i = 1'b0;
  logic [7:0] tpr_i = '0;
  logic [2:0] rd_sel_i = '0;
  logic ack_valid_o, irq_o;
  logic [7:0] ack_vec_o, ppr_o;
  logic [31:0] rd_irr_o, rd_isr_o, rd_tmr_o;

  int checks = 0;
  int fails  = 0;
  logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
  logic [8:0] exp_q [$];
  logic ack_seen = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  vip_core dut (
    .clk(clk), .rst(rst), .enable_i(enable_i), .post_valid_i(post_valid_i),
    .post_vec_i(post_vec_i), .post_level_i(post_level_i), .ack_req_i(ack_req_i),
    .ack_valid_o(ack_valid_o), .ack_vec_o(ack_vec_o), .eoi_i(eoi_i),
    .tpr_i(tpr_i), .irq_o(irq_o), .ppr_o(ppr_o), .rd_sel_i(rd_sel_i),
    .rd_irr_o(rd_irr_o), .rd_isr_o(rd_isr_o), .rd_tmr_o(rd_tmr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowest(input logic [255:0] a);
    for (int i = 0; i < 256; i++) if (a[i]) return i;
    return -1;
  endfunction

  // Monitor: compare acknowledge results against the scoreboard queue
  always @(posedge clk) ack_seen <= ack_req_i;
  always @(negedge clk) begin
    if (ack_seen && exp_q.size() > 0) begin
      logic [8:0] e;
      e = exp_q.pop_front();
      chk("R5/R6 ack_valid", {31'b0, ack_valid_o}, {31'b0, e[8]});
      if (e[8]) chk("R5 ack_vec", {24'b0, ack_vec_o}, {24'b0, e[7:0]});
    end
  end

  task automatic check_outs();
    int pi, si;
    logic [7:0] tc, sc, pexp;
    pi = lowest(m_irr);
    si = lowest(m_isr);
    chk("R4 irq", {31'b0, irq_o}, {31'b0, (pi >= 0) && (si < 0 || pi < si)});
    tc = tpr_i >> 4;
    sc = (si < 0) ? 8'd0 : 8'(si >> 4);
    pexp = (tc >= sc) ? tpr_i : 8'(sc << 4);
    chk("R8 ppr", {24'b0, ppr_o}, {24'b0, pexp});
  endtask

  // Driver: one clock of stimulus, model updated in the required order
  task automatic step(input logic pv, input logic [7:0] vec, input logic lvl,
                      input logic ack, input logic eoi);
    int pi, si;
    @(negedge clk);
    post_valid_i = pv; post_vec_i = vec; post_level_i = lvl;
    ack_req_i = ack; eoi_i = eoi;
    pi = lowest(m_irr);
    si = lowest(m_isr);
    if (ack) begin
      if (enable_i && pi >= 0) exp_q.push_back({1'b1, 8'(pi)});
      else exp_q.push_back(9'h000);
    end
    if (ack && enable_i && pi >= 0) m_irr[pi] = 1'b0;
    if (pv) begin m_irr[vec] = 1'b1; m_tmr[vec] = lvl; end
    if (eoi && si >= 0) m_isr[si] = 1'b0;
    if (ack && enable_i && pi >= 0) m_isr[pi] = 1'b1;
    @(negedge clk);
    post_valid_i = 1'b0; ack_req_i = 1'b0; eoi_i = 1'b0;
    check_outs();
  endtask

  task automatic rd_check(input logic [2:0] w, input string req);
    @(negedge clk);
    rd_sel_i = w;
    @(negedge clk);
    chk({req, " irr word"}, rd_irr_o, m_irr[w*32 +: 32]);
    chk({req, " isr word"}, rd_isr_o, m_isr[w*32 +: 32]);
    chk({req, " tmr word"}, rd_tmr_o, m_tmr[w*32 +: 32]);
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq after reset", {31'b0, irq_o}, 32'd0);
    chk("R10 ack_valid after reset", {31'b0, ack_valid_o}, 32'd0);
    rd_check(3'd0, "R10");
    // R3 / R1 edge post in word 1
    step(1, 8'd40, 0, 0, 0);
    rd_check(3'd1, "R1 R3 edge");
    step(1, 8'd200, 1, 0, 0);
    rd_check(3'd6, "R1 R3 level");
    // R5 ack gives 40; R8 class branch
    step(0, 0, 0, 1, 0);
    tpr_i = 8'h35;
    @(negedge clk);
    check_outs();
    step(0, 0, 0, 1, 0);
    rd_check(3'd6, "R5 isr");
    // R7 EOI retires lowest in service
    step(0, 0, 0, 0, 1);
    rd_check(3'd1, "R7 eoi");
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    rd_check(3'd6, "R7 empty eoi");
    // R6 ack with nothing pending
    step(0, 0, 0, 1, 0);
    // R6 ack while disabled
    tpr_i = 8'h00;
    step(1, 8'd5, 0, 0, 0);
    enable_i = 1'b0;
    step(0, 0, 0, 1, 0);
    rd_check(3'd0, "R6 disabled");
    enable_i = 1'b1;
    // R9 post and ack of the same vector together
    step(1, 8'd5, 1, 1, 0);
    rd_check(3'd0, "R9 same vector");
    // R4 strict less-than rule
    step(1, 8'd3, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1);
    // R2 lowest index across words
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1);
    step(1, 8'd255, 0, 0, 0);
    step(1, 8'd32, 1, 0, 0);
    step(1, 8'd31, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    rd_check(3'd7, "R2 top word");
    // R10 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_irr = '0; m_isr = '0; m_tmr = '0;
    @(negedge clk);
    check_outs();
    rd_check(3'd1, "R10 mid-run");
    repeat (3) @(negedge clk);
    chk("R5 queue drained", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule